// File: doc/BRIEF.md
# Cascaded Bartlett Averaging Filter

This block low-pass filters a stream of signed 14-bit rate samples. Two identical boxcar averagers run in series. Each averages the most recent N = 2^m accepted samples, so the pair has a triangular (Bartlett) impulse response. The division by N is an arithmetic right shift by m, which rounds toward minus infinity. A sample enters only in a cycle where the sample-valid input is high. A filtered value leaves with a one-cycle valid strobe.

The tap exponent m is a 3-bit setting. A range code can raise m to a minimum, because the narrower measurement ranges need more averaging to keep their resolution. The block registers the effective exponent. Whenever that exponent changes, both averagers are emptied and the output stays silent until they have filled again. A larger N gives more smoothing but a longer delay. m = 0 passes samples through unchanged.

Top module: `tri_avg_filter`

## Requirements
- R1: After a synchronous reset, `out_vld` is 0 and `out_data` is 0.
- R2: With an effective m of 0, every accepted sample reappears unchanged on `out_data`, with `out_vld` high, two clock cycles after it was accepted.
- R3: Each stage outputs floor(sum of its last N inputs / N), with N = 2^m. The second stage takes only the valid outputs of the first stage. `out_data` is the second stage's result.
- R4: The effective m is the larger of `taps_log2` and a floor set by `range_sel`: code 3'b010 gives a floor of 2, code 3'b001 gives a floor of 4, and 3'b100 or any other code gives a floor of 0.
- R5: When the effective m differs from the registered one, both stages are emptied. The first valid output then needs 2N-1 newly accepted samples, where N uses the new exponent.
- R6: `out_vld` is high in exactly those cycles two clocks after an accepted sample whose arrival found both stages full or completed their filling. Each pulse lasts one cycle. Without an accepted sample there is no pulse.
- R7: A sample presented in the cycle when the effective m changes is discarded.
- R8: A change of `taps_log2` that leaves the effective m unchanged has no effect: there is no flush and the output stream continues.
- R9: The output is kept within the signed 14-bit range. Full-scale inputs give exactly 8191 or -8192.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Input sample valid |
| smp_data | input | 14 | Signed input sample |
| taps_log2 | input | 3 | Requested exponent m, N = 2^m per stage |
| range_sel | input | 3 | Range code that sets the minimum m |
| out_vld | output | 1 | Filtered output valid strobe |
| out_data | output | 14 | Signed filtered output |

## Verification
A stale running sum or a fill count that went wrong shows up as a wrong `out_data`, either on the first valid output after a flush or on the output N samples later, when the sample being retired is subtracted. A fill count that is off by one moves the first `out_vld` one sample early or late. The bench compares against a queue-based model on every cycle, so such a fault is reported within one window of 2N samples. A missed flush or a wrong range floor changes the tap count, which leaves the whole following stream mismatched.

// File: rtl/tri_avg_pkg.sv
// Shared constants for the cascaded averaging filter.
// Assumes the range codes are one-hot. Any code other than the two narrow
// ones leaves the exponent unconstrained.
package tri_avg_pkg;
    localparam logic [2:0] RNG_WIDE    = 3'b100;
    localparam logic [2:0] RNG_HALF    = 3'b010;
    localparam logic [2:0] RNG_QUARTER = 3'b001;
    localparam int         HALF_MIN_M    = 2;
    localparam int         QUARTER_MIN_M = 4;

    // Minimum tap exponent demanded by a range code
    function automatic int range_floor(input logic [2:0] code);
        case (code)
            RNG_HALF:    return HALF_MIN_M;
            RNG_QUARTER: return QUARTER_MIN_M;
            default:     return 0;
        endcase
    endfunction
endpackage

// File: rtl/tri_avg_resolve.sv
// Resolves the effective tap exponent from the request and the range code.
// It holds the exponent in a register and raises flush for one cycle
// whenever the resolved value differs from the held one.
// Assumes M_W >= 3 so that the range floors fit.
module tri_avg_resolve
    import tri_avg_pkg::*;
#(
    parameter int M_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] taps_req,
    input  logic [2:0]     range_sel,
    output logic [M_W-1:0] m_cur,
    output logic           flush
);
    logic [M_W-1:0] floor_m;
    logic [M_W-1:0] want_m;

    // Pick the larger of the request and the range floor
    always_comb begin
        floor_m = M_W'(range_floor(range_sel));
        want_m  = (taps_req > floor_m) ? taps_req : floor_m;
        flush   = (want_m != m_cur);
    end

    // Hold the exponent the stages are currently using
    always_ff @(posedge clk) begin
        if (!rst_n) m_cur <= '0;
        else        m_cur <= want_m;
    end
endmodule

// File: rtl/tri_avg_stage.sv
// One boxcar averaging stage: a running sum over the last 2^m inputs, kept
// in a circular buffer sized for the largest m. The result is the sum shifted
// right arithmetically by m, clamped to DATA_W bits, and registered.
// Assumes m is constant between flushes. Flush empties the stage.
module tri_avg_stage #(
    parameter int DATA_W = 14,
    parameter int M_W    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [M_W-1:0]           m,
    input  logic                     in_vld,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] out_data
);
    localparam int MAX_LOG = (1 << M_W) - 1;
    localparam int DEPTH   = 1 << MAX_LOG;
    localparam int PTR_W   = MAX_LOG;
    localparam int CNT_W   = MAX_LOG + 1;
    localparam int SUM_W   = DATA_W + MAX_LOG;
    localparam int HI_I    = (1 << (DATA_W - 1)) - 1;
    localparam int LO_I    = -(1 << (DATA_W - 1));
    localparam logic signed [SUM_W-1:0] HI_S = SUM_W'(HI_I);
    localparam logic signed [SUM_W-1:0] LO_S = SUM_W'(LO_I);

    logic signed [DATA_W-1:0] ring [DEPTH];
    logic [PTR_W-1:0]         ptr;
    logic [CNT_W-1:0]         fill;
    logic signed [SUM_W-1:0]  sum;

    logic [CNT_W-1:0]         n_taps;
    logic                     full;
    logic [CNT_W-1:0]         fill_nxt;
    logic                     will_full;
    logic                     ptr_last;
    logic signed [DATA_W-1:0] oldest;
    logic signed [SUM_W-1:0]  sum_nxt;
    logic signed [SUM_W-1:0]  avg_full;
    logic signed [DATA_W-1:0] avg_sat;

    // Next sum, window status and the clamped average
    always_comb begin
        n_taps    = CNT_W'(1) << m;
        full      = (fill == n_taps);
        fill_nxt  = full ? fill : fill + CNT_W'(1);
        will_full = (fill_nxt == n_taps);
        ptr_last  = (ptr == PTR_W'(n_taps - CNT_W'(1)));
        oldest    = full ? ring[ptr] : '0;
        sum_nxt   = sum + SUM_W'(in_data) - SUM_W'(oldest);
        avg_full  = sum_nxt >>> m;
        if (avg_full > HI_S)      avg_sat = DATA_W'(HI_I);
        else if (avg_full < LO_S) avg_sat = DATA_W'(LO_I);
        else                      avg_sat = avg_full[DATA_W-1:0];
    end

    // Store the accepted sample; the buffer needs no reset because fill gates reads
    always_ff @(posedge clk) begin
        if (!flush && in_vld) ring[ptr] <= in_data;
    end

    // Advance the sum, pointer, fill count and registered output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum      <= '0;
            fill     <= '0;
            ptr      <= '0;
            out_vld  <= 1'b0;
            out_data <= '0;
        end else if (flush) begin
            sum     <= '0;
            fill    <= '0;
            ptr     <= '0;
            out_vld <= 1'b0;
        end else if (in_vld) begin
            sum     <= sum_nxt;
            fill    <= fill_nxt;
            ptr     <= ptr_last ? '0 : ptr + PTR_W'(1);
            out_vld <= will_full;
            if (will_full) out_data <= avg_sat;
        end else begin
            out_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/tri_avg_filter.sv
// Top of the cascaded Bartlett averaging filter. It resolves the tap
// exponent, then runs two identical boxcar stages in series that share the
// exponent and the flush. Latency is two clocks from an accepted sample.
// Assumes samples are signed DATA_W-bit values.
module tri_avg_filter #(
    parameter int DATA_W = 14,
    parameter int M_W    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_vld,
    input  logic signed [DATA_W-1:0] smp_data,
    input  logic [M_W-1:0]           taps_log2,
    input  logic [2:0]               range_sel,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] out_data
);
    localparam int N_STAGES = 2;

    logic [M_W-1:0]           m_cur;
    logic                     flush;
    logic                     vld_chain [N_STAGES+1];
    logic signed [DATA_W-1:0] dat_chain [N_STAGES+1];

    tri_avg_resolve #(.M_W(M_W)) u_resolve (
        .clk       (clk),
        .rst_n     (rst_n),
        .taps_req  (taps_log2),
        .range_sel (range_sel),
        .m_cur     (m_cur),
        .flush     (flush)
    );

    // Feed the chain from the input port
    always_comb begin
        vld_chain[0] = smp_vld;
        dat_chain[0] = smp_data;
    end

    for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
        tri_avg_stage #(.DATA_W(DATA_W), .M_W(M_W)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .m        (m_cur),
            .in_vld   (vld_chain[g]),
            .in_data  (dat_chain[g]),
            .out_vld  (vld_chain[g+1]),
            .out_data (dat_chain[g+1])
        );
    end

    // Drive the ports from the last stage
    always_comb begin
        out_vld  = vld_chain[N_STAGES];
        out_data = dat_chain[N_STAGES];
    end
endmodule

// File: rtl/tri_avg_checker.sv
// Port-level properties of the averaging filter, bound to the top module.
// It keeps its own copy of the previous effective exponent, worked out from
// the setting ports, to recognise flush cycles.
module tri_avg_checker #(
    parameter int DATA_W = 14,
    parameter int M_W    = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     smp_vld,
    input logic signed [DATA_W-1:0] smp_data,
    input logic [M_W-1:0]           taps_log2,
    input logic [2:0]               range_sel,
    input logic                     out_vld,
    input logic signed [DATA_W-1:0] out_data
);
    logic [M_W-1:0] eff;
    logic [M_W-1:0] eff_prev;
    logic           chg;

    // Effective exponent seen at the ports
    always_comb begin
        case (range_sel)
            3'b010:  eff = (taps_log2 > M_W'(2)) ? taps_log2 : M_W'(2);
            3'b001:  eff = (taps_log2 > M_W'(4)) ? taps_log2 : M_W'(4);
            default: eff = taps_log2;
        endcase
        chg = (eff != eff_prev);
    end

    // Previous effective exponent, cleared by reset like the design
    always_ff @(posedge clk) begin
        if (!rst_n) eff_prev <= '0;
        else        eff_prev <= eff;
    end

    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> (!out_vld && out_data == '0));

    p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(eff_prev, 1) == '0) |-> out_data == $past(smp_data, 2));

    p_flush_silence_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> !out_vld);

    p_flush_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> !$past(chg, 2));

    p_needs_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(smp_vld, 2));
endmodule

bind tri_avg_filter tri_avg_checker #(.DATA_W(DATA_W), .M_W(M_W)) u_chk (.*);

// File: tb/tri_avg_filter_tb.sv
// Bench for the averaging filter: a queue-based model stepped on every
// rising edge and compared at every falling edge, plus targeted checks.
module tri_avg_filter_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_vld = 1'b0;
    logic signed [13:0] smp_data = '0;
    logic [2:0]        taps_log2 = '0;
    logic [2:0]        range_sel = 3'b100;
    logic              out_vld;
    logic signed [13:0] out_data;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    // Model state
    int q1[$];
    int q2[$];
    int cm = 0;
    bit p1v = 0;
    int p1d = 0;
    bit e_vld = 0;
    int e_dat = 0;

    always #4 clk = ~clk;

    tri_avg_filter u_dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .taps_log2(taps_log2), .range_sel(range_sel),
        .out_vld(out_vld), .out_data(out_data)
    );

    function automatic int eff_of(input logic [2:0] t, input logic [2:0] r);
        int fl = (r == 3'b010) ? 2 : (r == 3'b001) ? 4 : 0;
        return (int'(t) > fl) ? int'(t) : fl;
    endfunction

    function automatic int clamp14(input int v);
        if (v > 8191) return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    // Reference model, one step per rising edge
    always @(posedge clk) begin
        int e;
        int n;
        int s;
        bit nv;
        if (!rst_n) begin
            q1.delete(); q2.delete(); cm = 0; p1v = 0; e_vld = 0; e_dat = 0;
        end else begin
            e = eff_of(taps_log2, range_sel);
            if (e != cm) begin
                q1.delete(); q2.delete(); p1v = 0; e_vld = 0; cm = e;
            end else begin
                n = 1 << cm;
                e_vld = 0;
                if (p1v) begin
                    q2.push_back(p1d);
                    if (q2.size() > n) void'(q2.pop_front());
                    if (q2.size() == n) begin
                        s = 0;
                        foreach (q2[i]) s += q2[i];
                        e_vld = 1; e_dat = clamp14(s >>> cm);
                    end
                end
                nv = 0;
                if (smp_vld) begin
                    q1.push_back(int'(smp_data));
                    if (q1.size() > n) void'(q1.pop_front());
                    if (q1.size() == n) begin
                        s = 0;
                        foreach (q1[i]) s += q1[i];
                        nv = 1; p1d = clamp14(s >>> cm);
                    end
                end
                p1v = nv;
            end
        end
    end

    // Cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (out_vld !== e_vld || (e_vld && out_data !== 14'(e_dat))) begin
                errors++;
                $display("FAIL %s: vld=%0b data=%0d expected vld=%0b data=%0d",
                         tag, out_vld, out_data, e_vld, e_dat);
            end
        end
    end

    task automatic check(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic feed(input int cycles, input int pct, input int lo, input int hi);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            smp_vld  = ($urandom_range(99) < pct);
            smp_data = 14'($urandom_range(hi - lo) + lo);
        end
        @(negedge clk);
        smp_vld = 0;
    endtask

    task automatic set_cfg(input logic [2:0] t, input logic [2:0] r);
        @(negedge clk);
        smp_vld = 0; taps_log2 = t; range_sel = r;
        @(negedge clk);
    endtask

    // Count negedges from the first sample until the first valid output
    task automatic first_out(input string t, input int n, input int val);
        int cnt = 0;
        smp_vld = 1; smp_data = 14'(val);
        do begin
            @(negedge clk);
            cnt++;
        end while (!out_vld && cnt < 400);
        check(t, cnt, 2 * n);
        check(t, int'(out_data), val);
        smp_vld = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 vld", int'(out_vld), 0);
        check("R1 data", int'(out_data), 0);
        rst_n = 1;
        @(negedge clk);

        // R2: m = 0 passes samples through with two cycles of latency
        tag = "R2";
        set_cfg(3'd0, 3'b100);
        @(negedge clk); smp_vld = 1; smp_data = 14'sd1234;
        @(negedge clk); smp_vld = 0;
        @(negedge clk);
        check("R2 passthru", int'(out_data), 1234);
        check("R2 vld", int'(out_vld), 1);
        feed(60, 70, -8192, 8191);

        // R3: averaging with gaps in the valid stream
        tag = "R3";
        set_cfg(3'd3, 3'b100);
        feed(300, 60, -8192, 8191);
        set_cfg(3'd1, 3'b100);
        feed(100, 90, -500, 500);

        // R4 and R5: range floors and refill after a flush
        tag = "R4";
        set_cfg(3'd1, 3'b001);
        first_out("R4/R5 quarter floor", 16, 1000);
        set_cfg(3'd0, 3'b010);
        first_out("R4/R5 half floor", 4, -300);
        set_cfg(3'd5, 3'b010);
        first_out("R4 request above floor", 32, 77);
        set_cfg(3'd0, 3'b111);
        first_out("R4 other code no floor", 1, 5);
        set_cfg(3'd2, 3'b001);
        feed(200, 80, -4000, 4000);

        // R8: raising the request while it stays below the floor has no effect
        tag = "R8";
        set_cfg(3'd0, 3'b001);
        feed(60, 100, -100, 100);
        @(negedge clk); taps_log2 = 3'd3; smp_vld = 1; smp_data = 14'sd10;
        @(negedge clk); smp_vld = 0;
        @(negedge clk);
        check("R8 no flush", int'(out_vld), 1);
        feed(40, 80, -100, 100);

        // R7: sample present in the cycle when the exponent changes
        tag = "R7";
        feed(30, 100, -2000, 2000);
        @(negedge clk); taps_log2 = 3'd2; range_sel = 3'b100; smp_vld = 1; smp_data = 14'sd999;
        feed(80, 100, -2000, 2000);

        // R9 and R6: largest window at full scale
        tag = "R9";
        set_cfg(3'd7, 3'b100);
        first_out("R9 full positive", 128, 8191);
        set_cfg(3'd6, 3'b100);
        first_out("R9 full negative", 64, -8192);
        tag = "R6";
        feed(400, 50, -8192, 8191);
        repeat (4) @(negedge clk);
        check("R6 idle no pulse", int'(out_vld), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule